// File: doc/BRIEF.md
# Keyboard Controller Host Command Engine

This block is the processor-facing side of a PS/2-style keyboard controller. It has a byte-wide register bus. When `bus_sel` is low the bus reaches the data port. When `bus_sel` is high it reaches the command/status port. The block holds the controller's mode byte, its status byte and its output-port byte. It decodes one-byte controller commands written to the command port and puts the replies into a small reply FIFO, which the host drains through the data port.

Five commands latch themselves into a pending-command register and wait for a second byte on the data port. The next data write completes that command and clears the latch. A data write made while nothing is pending goes out on the keyboard transmit strobe. The output port drives the A20 gate line directly and can request a CPU reset. Every command in the top sixteen codes folds into either a reset request or a no-op. The interrupt lines follow the FIFO head and the mode byte.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset the mode byte is 0x03, the status byte is 0x18, the output port is 0xCF, a20_out is 1, translate_en is 0, and the reply FIFO is empty.
- R2: A read with bus_sel=1 returns the status byte. Its bit layout is: bit 0 set while the reply FIFO is not empty; bit 2 set after a self-test; bits 3 and 4 always 1; bit 5 set while the FIFO head came from the auxiliary side; bits 1, 6 and 7 always 0.
- R3: A read with bus_sel=0 returns the oldest FIFO entry and removes it. The FIFO keeps first-in first-out order. A read of an empty FIFO returns 0x00.
- R4: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only latch. The next data write completes them: 0xD2 queues the byte as keyboard data, 0xD3 queues it as auxiliary data, and 0xD4 pulses aux_tx_valid with the byte. After that one write the latch is clear.
- R5: A data write with no latch pending pulses kbd_tx_valid for one cycle, with the byte on kbd_tx_data.
- R6: Command 0x20 queues the mode byte and command 0xC0 queues 0x80. Command 0xD0 queues the output port with bit 4 replaced by "FIFO not empty" and bit 5 replaced by "FIFO head is auxiliary".
- R7: Command 0xAA sets status bit 2 and queues 0x55. Commands 0xA9 and 0xAB each queue 0x00.
- R8: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4. irq_kbd is high when the FIFO head is keyboard data, mode bit 0 is 1 and mode bit 4 is 0. irq_aux is high when the FIFO head is auxiliary data and mode bit 1 is 1.
- R9: A command in 0xF0..0xFF with bit 0 clear raises reset_req for exactly one cycle. A command in that range with bit 0 set changes nothing.
- R10: Command 0xDF sets output-port bit 1 and a20_out. Command 0xDD clears both.
- R11: The data byte that completes 0xD1 becomes the output port. a20_out follows its bit 1, and a 0 in its bit 0 raises reset_req for one cycle.
- R12: Any other command code raises cmd_err for one cycle and changes no state.
- R13: The data byte that completes 0x60 becomes the mode byte, and translate_en follows its bit 6.
- R14: The reply FIFO holds QDEPTH entries (4 by default). A reply pushed while the FIFO is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | 0 = data port, 1 = command/status port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a data-port read pops the FIFO |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| kbd_tx_valid | output | 1 | One-cycle strobe: byte for the keyboard |
| kbd_tx_data | output | 8 | Byte for the keyboard |
| aux_tx_valid | output | 1 | One-cycle strobe: byte for the auxiliary device |
| aux_tx_data | output | 8 | Byte for the auxiliary device |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |
| a20_out | output | 1 | A20 gate level (output-port bit 1) |
| reset_req | output | 1 | One-cycle CPU reset request |
| translate_en | output | 1 | Scan-code translation enable (mode bit 6) |
| cmd_err | output | 1 | One-cycle unknown-command flag |

## Verification
Most internal state is visible at the ports only through replies. A wrong mode or output-port byte shows up on the first 0x20 or 0xD0 reply. A wrong interrupt level shows up in the cycle after the write that caused it. A latch that fails to clear does not show up until the following data write, which then lands in the FIFO instead of on the keyboard strobe. A FIFO ordering or tagging fault shows up in the status bit 5 read and the data read that follow the push. A missed or stretched reset pulse is visible one cycle after its command.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

   localparam logic [7:0] OP_RD_MODE   = 8'h20;
   localparam logic [7:0] OP_WR_MODE   = 8'h60;
   localparam logic [7:0] OP_AUX_OFF   = 8'hA7;
   localparam logic [7:0] OP_AUX_ON    = 8'hA8;
   localparam logic [7:0] OP_AUX_TEST  = 8'hA9;
   localparam logic [7:0] OP_SELFTEST  = 8'hAA;
   localparam logic [7:0] OP_KBD_TEST  = 8'hAB;
   localparam logic [7:0] OP_KBD_OFF   = 8'hAD;
   localparam logic [7:0] OP_KBD_ON    = 8'hAE;
   localparam logic [7:0] OP_RD_INPUT  = 8'hC0;
   localparam logic [7:0] OP_RD_OPORT  = 8'hD0;
   localparam logic [7:0] OP_WR_OPORT  = 8'hD1;
   localparam logic [7:0] OP_WR_KQUEUE = 8'hD2;
   localparam logic [7:0] OP_WR_AQUEUE = 8'hD3;
   localparam logic [7:0] OP_TO_AUX    = 8'hD4;
   localparam logic [7:0] OP_GATE_OFF  = 8'hDD;
   localparam logic [7:0] OP_GATE_ON   = 8'hDF;

   typedef enum logic [3:0] {
      ACT_NONE,
      ACT_LATCH,
      ACT_Q_MODE,
      ACT_Q_OPORT,
      ACT_Q_INPUT,
      ACT_SELFTEST,
      ACT_Q_ZERO,
      ACT_AUX_OFF,
      ACT_AUX_ON,
      ACT_KBD_OFF,
      ACT_KBD_ON,
      ACT_GATE_ON,
      ACT_GATE_OFF,
      ACT_CPU_RST,
      ACT_BAD
   } kbc_act_e;

   typedef struct packed {
      logic       aux;
      logic [7:0] dat;
   } kbc_entry_t;

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
   import kbc_pkg::*;
(
   input  logic [7:0] cmd,
   output kbc_act_e   act
);

   always_comb begin
      if (cmd[7:4] == 4'hF) begin
         act = cmd[0] ? ACT_NONE : ACT_CPU_RST;
      end else begin
         unique case (cmd)
            OP_RD_MODE:   act = ACT_Q_MODE;
            OP_WR_MODE,
            OP_WR_OPORT,
            OP_WR_KQUEUE,
            OP_WR_AQUEUE,
            OP_TO_AUX:    act = ACT_LATCH;
            OP_AUX_OFF:   act = ACT_AUX_OFF;
            OP_AUX_ON:    act = ACT_AUX_ON;
            OP_AUX_TEST,
            OP_KBD_TEST:  act = ACT_Q_ZERO;
            OP_SELFTEST:  act = ACT_SELFTEST;
            OP_KBD_OFF:   act = ACT_KBD_OFF;
            OP_KBD_ON:    act = ACT_KBD_ON;
            OP_RD_INPUT:  act = ACT_Q_INPUT;
            OP_RD_OPORT:  act = ACT_Q_OPORT;
            OP_GATE_OFF:  act = ACT_GATE_OFF;
            OP_GATE_ON:   act = ACT_GATE_ON;
            default:      act = ACT_BAD;
         endcase
      end
   end

endmodule

// File: rtl/kbc_reply_fifo.sv
module kbc_reply_fifo
   import kbc_pkg::*;
#(
   parameter int DEPTH = 4
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  kbc_entry_t push_entry,
   input  logic       pop,
   output logic       empty,
   output logic       full,
   output kbc_entry_t head
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("kbc_reply_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic       valid;
      kbc_entry_t slot;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid <= 1'b0;
            slot  <= '0;
         end else if (push && (!valid || pop)) begin
            valid <= 1'b1;
            slot  <= push_entry;
         end else if (pop) begin
            valid <= 1'b0;
         end
      end

      assign empty = !valid;
      assign full  = valid;
      assign head  = slot;
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);
      localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

      kbc_entry_t          mem [DEPTH];
      logic [PW-1:0]       wp, rp;
      logic [CW-1:0]       cnt;
      logic                do_push, do_pop;

      assign do_pop  = pop && (cnt != '0);
      assign do_push = push && ((cnt != CW'(DEPTH)) || do_pop);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
         end else begin
            if (do_push) begin
               mem[wp] <= push_entry;
               wp      <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
               rp <= (rp == LAST) ? '0 : rp + 1'b1;
            end
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
         end
      end

      assign empty = (cnt == '0);
      assign full  = (cnt == CW'(DEPTH));
      assign head  = mem[rp];

      p_cnt_bound_r14: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CW'(DEPTH));
      p_full_drop_r14: assert property (@(posedge clk) disable iff (!rst_n)
         (full && push && !pop) |=> full);
   end

endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
   import kbc_pkg::*;
#(
   parameter int         QDEPTH         = 4,
   parameter logic [7:0] MODE_RST       = 8'h03,
   parameter logic [7:0] OPORT_RST      = 8'hCF,
   parameter logic [7:0] INPUT_VAL      = 8'h80,
   parameter logic [7:0] SELFTEST_REPLY = 8'h55
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       kbd_tx_valid,
   output logic [7:0] kbd_tx_data,
   output logic       aux_tx_valid,
   output logic [7:0] aux_tx_data,
   output logic       irq_kbd,
   output logic       irq_aux,
   output logic       a20_out,
   output logic       reset_req,
   output logic       translate_en,
   output logic       cmd_err
);

   localparam int B_KBD_INT = 0;
   localparam int B_AUX_INT = 1;
   localparam int B_KBD_DIS = 4;
   localparam int B_AUX_DIS = 5;
   localparam int B_XLATE   = 6;

   logic       wr_cmd, wr_dat, rd_dat;
   kbc_act_e   act;
   logic [7:0] mode;
   logic [1:0] oport_hi;
   logic [3:0] oport_lo;
   logic [7:0] pend;
   logic       st_pass;
   logic       q_push, q_empty, q_full;
   kbc_entry_t q_entry, q_head;
   logic       head_aux, obf;
   logic [7:0] status, oport_view;

   assign wr_cmd = bus_wr && bus_sel;
   assign wr_dat = bus_wr && !bus_sel;
   assign rd_dat = bus_rd && !bus_sel;

   kbc_cmd_decode u_dec (
      .cmd (bus_wdata),
      .act (act)
   );

   kbc_reply_fifo #(.DEPTH(QDEPTH)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (q_push),
      .push_entry (q_entry),
      .pop        (rd_dat),
      .empty      (q_empty),
      .full       (q_full),
      .head       (q_head)
   );

   assign obf        = !q_empty;
   assign head_aux   = obf && q_head.aux;
   assign status     = {2'b00, head_aux, 2'b11, st_pass, 1'b0, obf};
   assign oport_view = {oport_hi, head_aux, obf, oport_lo};
   assign bus_rdata  = bus_sel ? status : (q_empty ? 8'h00 : q_head.dat);

   always_comb begin
      q_push  = 1'b0;
      q_entry = '0;
      if (wr_cmd) begin
         q_push = 1'b1;
         unique case (act)
            ACT_Q_MODE:   q_entry.dat = mode;
            ACT_Q_OPORT:  q_entry.dat = oport_view;
            ACT_Q_INPUT:  q_entry.dat = INPUT_VAL;
            ACT_SELFTEST: q_entry.dat = SELFTEST_REPLY;
            ACT_Q_ZERO:   q_entry.dat = 8'h00;
            default:      q_push      = 1'b0;
         endcase
      end else if (wr_dat && (pend == OP_WR_KQUEUE || pend == OP_WR_AQUEUE)) begin
         q_push      = 1'b1;
         q_entry.aux = (pend == OP_WR_AQUEUE);
         q_entry.dat = bus_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode         <= MODE_RST;
         oport_hi     <= OPORT_RST[7:6];
         oport_lo     <= OPORT_RST[3:0];
         pend         <= 8'h00;
         st_pass      <= 1'b0;
         kbd_tx_valid <= 1'b0;
         kbd_tx_data  <= 8'h00;
         aux_tx_valid <= 1'b0;
         aux_tx_data  <= 8'h00;
         reset_req    <= 1'b0;
         cmd_err      <= 1'b0;
      end else begin
         kbd_tx_valid <= 1'b0;
         aux_tx_valid <= 1'b0;
         reset_req    <= 1'b0;
         cmd_err      <= 1'b0;
         if (wr_cmd) begin
            unique case (act)
               ACT_LATCH:    pend              <= bus_wdata;
               ACT_SELFTEST: st_pass           <= 1'b1;
               ACT_AUX_OFF:  mode[B_AUX_DIS]   <= 1'b1;
               ACT_AUX_ON:   mode[B_AUX_DIS]   <= 1'b0;
               ACT_KBD_OFF:  mode[B_KBD_DIS]   <= 1'b1;
               ACT_KBD_ON:   mode[B_KBD_DIS]   <= 1'b0;
               ACT_GATE_ON:  oport_lo[1]       <= 1'b1;
               ACT_GATE_OFF: oport_lo[1]       <= 1'b0;
               ACT_CPU_RST:  reset_req         <= 1'b1;
               ACT_BAD:      cmd_err           <= 1'b1;
               default:      ;
            endcase
         end else if (wr_dat) begin
            pend <= 8'h00;
            unique case (pend)
               8'h00: begin
                  kbd_tx_valid <= 1'b1;
                  kbd_tx_data  <= bus_wdata;
               end
               OP_WR_MODE:  mode <= bus_wdata;
               OP_WR_OPORT: begin
                  oport_hi  <= bus_wdata[7:6];
                  oport_lo  <= bus_wdata[3:0];
                  reset_req <= !bus_wdata[0];
               end
               OP_TO_AUX: begin
                  aux_tx_valid <= 1'b1;
                  aux_tx_data  <= bus_wdata;
               end
               default: ;
            endcase
         end
      end
   end

   assign a20_out      = oport_lo[1];
   assign translate_en = mode[B_XLATE];
   assign irq_kbd      = obf && !head_aux && mode[B_KBD_INT] && !mode[B_KBD_DIS];
   assign irq_aux      = head_aux && mode[B_AUX_INT];

   p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);
   p_err_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> !cmd_err);
   p_tx_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      kbd_tx_valid |-> $past(bus_wr && !bus_sel));
   p_gate_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(a20_out) |-> $past(bus_wr));
   p_selftest_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st_pass |=> st_pass);
   p_push_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && !rd_dat) |=> !q_empty);
   p_irq_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_kbd && irq_aux));
   p_q_full_dbg_r14: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> obf);

endmodule

// File: tb/sim_kbc_cmd_engine.sv
module sim_kbc_cmd_engine;
   localparam int CLK_PERIOD = 10;
   localparam int QD = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       kbd_tx_valid, aux_tx_valid, irq_kbd, irq_aux;
   logic       a20_out, reset_req, translate_en, cmd_err;
   logic [7:0] kbd_tx_data, aux_tx_data;

   int total = 0;
   int bad = 0;
   logic [8:0] mq[$];
   logic       st_done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   kbc_cmd_engine #(.QDEPTH(QD)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .kbd_tx_valid(kbd_tx_valid), .kbd_tx_data(kbd_tx_data),
      .aux_tx_valid(aux_tx_valid), .aux_tx_data(aux_tx_data),
      .irq_kbd(irq_kbd), .irq_aux(irq_aux), .a20_out(a20_out),
      .reset_req(reset_req), .translate_en(translate_en), .cmd_err(cmd_err)
   );

   function automatic logic [7:0] exp_stat(input logic ne, input logic ha, input logic st);
      return {2'b00, ha, 2'b11, st, 1'b0, ne};
   endfunction

   function automatic logic [7:0] model_stat();
      logic ne = (mq.size() != 0);
      logic ha = ne && mq[0][8];
      return exp_stat(ne, ha, st_done);
   endfunction

   task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wcmd(input logic [7:0] b);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = b;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wdat(input logic [7:0] b);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = b;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rdat(output logic [7:0] v);
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rstat(output logic [7:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic expect_read(input string req, input logic [7:0] e);
      logic [7:0] v;
      rdat(v);
      chk(v == e, req, v, e);
   endtask

   task automatic expect_stat(input string req, input logic [7:0] e);
      logic [7:0] v;
      rstat(v);
      chk(v == e, req, v, e);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v, b;
      int op;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(a20_out == 1'b1, "R1 a20", {7'd0, a20_out}, 8'h01);
      chk(translate_en == 1'b0, "R1 xlate", {7'd0, translate_en}, 8'h00);
      expect_stat("R1 status", 8'h18);
      expect_read("R3 empty read", 8'h00);
      wcmd(8'h20); expect_read("R1 mode", 8'h03);
      wcmd(8'hD0); expect_read("R1 oport", 8'hCF);

      // R12 unknown command
      wcmd(8'h12);
      chk(cmd_err == 1'b1, "R12 err set", {7'd0, cmd_err}, 8'h01);
      @(negedge clk);
      chk(cmd_err == 1'b0, "R12 err one cycle", {7'd0, cmd_err}, 8'h00);
      expect_stat("R12 no queue", 8'h18);
      wcmd(8'h20); expect_read("R12 mode kept", 8'h03);

      // R6 input port, R7 tests
      wcmd(8'hC0); expect_read("R6 input", 8'h80);
      wcmd(8'hA9); expect_read("R7 aux test", 8'h00);
      wcmd(8'hAB); expect_read("R7 kbd test", 8'h00);
      wcmd(8'hAA); st_done = 1'b1;
      expect_stat("R7 selftest status", 8'h1D);
      expect_read("R7 selftest reply", 8'h55);
      expect_stat("R2 bit2 stays", 8'h1C);

      // R4/R5 latch then clear
      wcmd(8'hD2); wdat(8'h33);
      chk(kbd_tx_valid == 1'b0, "R4 no tx on latched", {7'd0, kbd_tx_valid}, 8'h00);
      wdat(8'h44);
      chk(kbd_tx_valid && kbd_tx_data == 8'h44, "R5 tx after clear", kbd_tx_data, 8'h44);
      @(negedge clk);
      chk(kbd_tx_valid == 1'b0, "R5 tx one cycle", {7'd0, kbd_tx_valid}, 8'h00);
      // R8 irq with keyboard head
      chk(irq_kbd == 1'b1 && irq_aux == 1'b0, "R8 irq kbd", {6'd0, irq_aux, irq_kbd}, 8'h01);
      wcmd(8'hAD);
      chk(irq_kbd == 1'b0, "R8 kbd disabled", {7'd0, irq_kbd}, 8'h00);
      wcmd(8'hAE);
      chk(irq_kbd == 1'b1, "R8 kbd enabled", {7'd0, irq_kbd}, 8'h01);
      expect_read("R4 queued kbd byte", 8'h33);
      chk(irq_kbd == 1'b0, "R8 irq drops empty", {7'd0, irq_kbd}, 8'h00);

      // R4 aux queue, R6 oport view, R2 bit5
      wcmd(8'hD3); wdat(8'hA5);
      chk(irq_aux == 1'b1 && irq_kbd == 1'b0, "R8 irq aux", {6'd0, irq_aux, irq_kbd}, 8'h02);
      expect_stat("R2 aux head", 8'h3D);
      wcmd(8'hD0);
      expect_read("R4 aux byte", 8'hA5);
      expect_read("R6 oport with flags", 8'hFF);
      wcmd(8'hA7); wcmd(8'hA8); wcmd(8'h20);
      expect_read("R8 aux bit cleared", 8'h03);
      wcmd(8'hA7); wcmd(8'h20);
      expect_read("R8 aux bit set", 8'h23);
      wcmd(8'hA8);

      // R4 send to aux
      wcmd(8'hD4); wdat(8'h5A);
      chk(aux_tx_valid && aux_tx_data == 8'h5A, "R4 aux tx", aux_tx_data, 8'h5A);
      chk(kbd_tx_valid == 1'b0, "R4 not kbd", {7'd0, kbd_tx_valid}, 8'h00);

      // R13 mode write
      wcmd(8'h60); wdat(8'h41);
      chk(translate_en == 1'b1, "R13 xlate", {7'd0, translate_en}, 8'h01);
      wcmd(8'hD3); wdat(8'h10);
      chk(irq_aux == 1'b0, "R8 aux irq masked", {7'd0, irq_aux}, 8'h00);
      expect_read("R4 aux byte 2", 8'h10);
      wcmd(8'h20); expect_read("R13 mode", 8'h41);
      wcmd(8'h60); wdat(8'h03);
      chk(translate_en == 1'b0, "R13 xlate off", {7'd0, translate_en}, 8'h00);

      // R9 pulse range
      wcmd(8'hF1);
      chk(reset_req == 1'b0 && cmd_err == 1'b0, "R9 odd noop", {6'd0, cmd_err, reset_req}, 8'h00);
      wcmd(8'hFF);
      chk(reset_req == 1'b0, "R9 ff noop", {7'd0, reset_req}, 8'h00);
      wcmd(8'hF4);
      chk(reset_req == 1'b1, "R9 even reset", {7'd0, reset_req}, 8'h01);
      @(negedge clk);
      chk(reset_req == 1'b0, "R9 one cycle", {7'd0, reset_req}, 8'h00);
      wcmd(8'hFE);
      chk(reset_req == 1'b1, "R9 fe reset", {7'd0, reset_req}, 8'h01);

      // R10 gate commands
      wcmd(8'hDD);
      chk(a20_out == 1'b0, "R10 gate off", {7'd0, a20_out}, 8'h00);
      wcmd(8'hD0); expect_read("R10 oport bit1 clr", 8'hCD);
      wcmd(8'hDF);
      chk(a20_out == 1'b1, "R10 gate on", {7'd0, a20_out}, 8'h01);

      // R11 output port write
      wcmd(8'hD1); wdat(8'h01);
      chk(a20_out == 1'b0 && reset_req == 1'b0, "R11 write 01", {6'd0, reset_req, a20_out}, 8'h00);
      wcmd(8'hD0); expect_read("R11 oport readback", 8'h01);
      wcmd(8'hD1); wdat(8'h02);
      chk(a20_out == 1'b1 && reset_req == 1'b1, "R11 write 02", {6'd0, reset_req, a20_out}, 8'h03);

      // R14 overflow
      for (int i = 1; i <= QD + 1; i++) begin
         wcmd(8'hD2); wdat(8'(i));
      end
      for (int i = 1; i <= QD; i++) expect_read("R14 order", 8'(i));
      expect_read("R14 dropped", 8'h00);

      // random mix against bench model
      mq.delete();
      for (int n = 0; n < 200; n++) begin
         op = int'($urandom_range(0, 4));
         b  = 8'($urandom());
         case (op)
            0: begin
               wdat(b);
               chk(kbd_tx_valid && kbd_tx_data == b, "R5 random tx", kbd_tx_data, b);
            end
            1, 2: begin
               wcmd(op == 1 ? 8'hD2 : 8'hD3); wdat(b);
               if (mq.size() < QD) mq.push_back({(op == 2), b});
            end
            3: begin
               v = (mq.size() != 0) ? mq[0][7:0] : 8'h00;
               if (mq.size() != 0) void'(mq.pop_front());
               expect_read("R3 random read", v);
            end
            default: expect_stat("R2 random status", model_stat());
         endcase
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule